// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block moves a CAN controller core between its three operating modes: sleep, initialization and normal. Software asks for a mode by writing request bits into a control register. The block answers through acknowledge bits in a status register, and software polls those bits until the change is confirmed. Entry into initialization or sleep waits until no frame is in progress and then passes a short synchronization delay. A return to normal operation completes only after the bus has been idle for a run of consecutive recessive bits.

A soft reset request in the control register puts the core back into sleep mode, with the sleep acknowledge set, rather than into normal operation. The status register also holds an error interrupt flag. A pulse from the error logic sets the flag, and software clears it by writing a one to it. The block drives three enables. One lets bit timing and filter settings be written, and it is open only in initialization mode. The other two gate the transmit and receive paths, which run only in normal mode. The bit-level protocol engine reports frame activity and sampled bus bits to this block. That engine, bit timing generation, clock gating and bus wake-up detection are outside the block.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the status reads 3'b010: bit 0 (init acknowledge) is 0, bit 1 (sleep acknowledge) is 1 and bit 2 (error flag) is 0. The control register reads 16'h0002, and the configuration, transmit and receive enables are all low.
- R2: Control bit 0 requests initialization. Once the bus is idle (bus_busy low), the init acknowledge (status bit 0) rises on the second clock edge after the write. While bus_busy is high, the acknowledge stays low.
- R3: Control bit 1 requests sleep. The sleep acknowledge (status bit 1) rises on the second clock edge after the request becomes the active target on an idle bus, whether the core comes from normal or from initialization mode.
- R4: When both request bits are clear, the current init or sleep acknowledge stays high until 11 consecutive valid recessive bits have been sampled. It drops on the edge that samples the eleventh. A valid dominant bit restarts the count.
- R5: When control bits 0 and 1 are both set, initialization mode is entered and held, and the sleep acknowledge stays low.
- R6: Writing control bit 15 as 1 is a soft reset. On that edge the core enters sleep mode, status becomes 3'b010 and the control register reads 16'h0002 (bit 15 always reads 0). This holds whatever else the same write sets.
- R7: An err_event pulse sets status bit 2. A status write with bit 2 = 1 clears it, and a status write with bit 2 = 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R8: cfg_wr_en is high exactly while the init acknowledge is high. tx_en and rx_en are high exactly while neither acknowledge is high, which is normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write data: bit 0 init request, bit 1 sleep request, bit 15 soft reset |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 3 | Status write data; a 1 in bit 2 clears the error flag |
| err_event | input | 1 | One-cycle pulse from error logic that sets the error flag |
| bus_busy | input | 1 | High while a frame is in progress on the bus |
| bit_valid | input | 1 | A sampled bus bit is presented this cycle |
| bit_recessive | input | 1 | Value of the sampled bit: 1 recessive, 0 dominant |
| ctrl_rdata | output | 16 | Control register read value |
| stat_rdata | output | 3 | Status: bit 0 init ack, bit 1 sleep ack, bit 2 error flag |
| cfg_wr_en | output | 1 | Bit timing and filter settings may be written |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |

## Verification
The bench targets the exact edge on which each acknowledge moves. Entry into a mode is checked one cycle early and on time, and a design with a wrong synchronization depth, or one that ignores bus_busy, would show the acknowledge too early. The exit counter is fed ten recessive bits after a dominant restart, which catches a design that fails to restart or counts one bit short and drops the acknowledge early. Three cases check precedence. With both requests set, a design that lets sleep win shows the wrong acknowledge. A soft reset carrying an init request must still land in sleep. An error set that coincides with a clear must keep the flag, or an event is silently lost.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int CTRL_W         = 16;
    localparam int CTRL_INIT_BIT  = 0;
    localparam int CTRL_SLEEP_BIT = 1;
    localparam int CTRL_SRST_BIT  = 15;

    localparam int STAT_W         = 3;
    localparam int STAT_INIT_BIT  = 0;
    localparam int STAT_SLEEP_BIT = 1;
    localparam int STAT_ERR_BIT   = 2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_INIT   = 2'd1,
        MODE_SLEEP  = 2'd2
    } mode_e;

    typedef struct packed {
        logic init_req;
        logic sleep_req;
    } mode_req_t;

    // Initialization request outranks sleep request.
    function automatic mode_e pick_target(mode_req_t r);
        if (r.init_req)
            return MODE_INIT;
        else if (r.sleep_req)
            return MODE_SLEEP;
        else
            return MODE_NORMAL;
    endfunction

endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_wr,
    input  logic              stat_clr_err,
    input  logic              err_event,
    output mode_req_t         req,
    output logic              soft_rst,
    output logic              err_flag,
    output logic [CTRL_W-1:0] ctrl_rdata
);

    assign soft_rst = ctrl_wr && ctrl_wdata[CTRL_SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            req.init_req  <= 1'b0;
            req.sleep_req <= 1'b1;
        end else if (ctrl_wr) begin
            req.init_req  <= ctrl_wdata[CTRL_INIT_BIT];
            req.sleep_req <= ctrl_wdata[CTRL_SLEEP_BIT];
        end
    end

    // Set has priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            err_flag <= 1'b0;
        else if (err_event)
            err_flag <= 1'b1;
        else if (stat_wr && stat_clr_err)
            err_flag <= 1'b0;
    end

    always_comb begin
        ctrl_rdata                 = '0;
        ctrl_rdata[CTRL_INIT_BIT]  = req.init_req;
        ctrl_rdata[CTRL_SLEEP_BIT] = req.sleep_req;
    end

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (err_event && !soft_rst) |=> err_flag);                           // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_clr_err && !err_event) |=> !err_flag);           // R7
    AST_SRST_REQ: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (req.sleep_req && !req.init_req));                   // R6

endmodule

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bit_valid,
    input  logic bit_recessive,
    output logic done
);

    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    logic [CW-1:0] run_cnt;

    assign done = arm && bit_valid && bit_recessive && (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm || done)
            run_cnt <= '0;
        else if (bit_valid)
            run_cnt <= bit_recessive ? run_cnt + 1'b1 : '0;
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_cnt < CW'(IDLE_BITS));                                        // R4
    AST_DOMINANT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (arm && bit_valid && !bit_recessive) |=> (run_cnt == '0));        // R4

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
#(
    parameter int SYNC_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  mode_req_t req,
    input  logic      soft_rst,
    input  logic      bus_busy,
    input  logic      idle_done,
    output logic      idle_arm,
    output mode_e     mode
);

    localparam int SW = $clog2(SYNC_CYCLES + 1);
    localparam logic [SW-1:0] SYNC_LAST = SW'(SYNC_CYCLES - 1);

    mode_e         target;
    logic          entering;
    logic [SW-1:0] sync_cnt;

    always_comb begin
        target   = pick_target(req);
        entering = (target != MODE_NORMAL) && (target != mode);
        idle_arm = (target == MODE_NORMAL) && (mode != MODE_NORMAL);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            mode     <= MODE_SLEEP;
            sync_cnt <= '0;
        end else if (entering) begin
            if (bus_busy) begin
                sync_cnt <= '0;
            end else if (sync_cnt == SYNC_LAST) begin
                mode     <= target;
                sync_cnt <= '0;
            end else begin
                sync_cnt <= sync_cnt + 1'b1;
            end
        end else begin
            sync_cnt <= '0;
            if (idle_arm && idle_done)
                mode <= MODE_NORMAL;
        end
    end

    AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mode) && mode != MODE_NORMAL && !$past(soft_rst))
            |-> !$past(bus_busy));                                        // R2
    AST_NORMAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mode) && mode == MODE_NORMAL) |-> $past(idle_done));    // R4
    AST_INIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INIT && req.init_req && !soft_rst)
            |=> (mode == MODE_INIT));                                     // R5
    AST_SRST_SLEEP: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (mode == MODE_SLEEP));                               // R6

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int SYNC_CYCLES = 2,
    parameter int IDLE_BITS   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              err_event,
    input  logic              bus_busy,
    input  logic              bit_valid,
    input  logic              bit_recessive,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              cfg_wr_en,
    output logic              tx_en,
    output logic              rx_en
);

    mode_req_t req;
    mode_e     mode;
    logic      soft_rst;
    logic      err_flag;
    logic      idle_arm;
    logic      idle_done;

    can_mode_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .stat_wr      (stat_wr),
        .stat_clr_err (stat_wdata[STAT_ERR_BIT]),
        .err_event    (err_event),
        .req          (req),
        .soft_rst     (soft_rst),
        .err_flag     (err_flag),
        .ctrl_rdata   (ctrl_rdata)
    );

    can_mode_fsm #(.SYNC_CYCLES(SYNC_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .soft_rst  (soft_rst),
        .bus_busy  (bus_busy),
        .idle_done (idle_done),
        .idle_arm  (idle_arm),
        .mode      (mode)
    );

    can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk           (clk),
        .rst           (rst),
        .arm           (idle_arm),
        .bit_valid     (bit_valid),
        .bit_recessive (bit_recessive),
        .done          (idle_done)
    );

    always_comb begin
        stat_rdata                 = '0;
        stat_rdata[STAT_INIT_BIT]  = (mode == MODE_INIT);
        stat_rdata[STAT_SLEEP_BIT] = (mode == MODE_SLEEP);
        stat_rdata[STAT_ERR_BIT]   = err_flag;
        cfg_wr_en                  = (mode == MODE_INIT);
        tx_en                      = (mode == MODE_NORMAL);
        rx_en                      = (mode == MODE_NORMAL);
    end

    AST_NO_EARLY_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(idle_done));                               // R8

endmodule

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctrl_wr;
    logic [15:0] ctrl_wdata;
    logic        stat_wr;
    logic [2:0]  stat_wdata;
    logic        err_event;
    logic        bus_busy;
    logic        bit_valid;
    logic        bit_recessive;
    logic [15:0] ctrl_rdata;
    logic [2:0]  stat_rdata;
    logic        cfg_wr_en;
    logic        tx_en;
    logic        rx_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    can_mode_seq uut (
        .clk           (clk),
        .rst           (rst),
        .ctrl_wr       (ctrl_wr),
        .ctrl_wdata    (ctrl_wdata),
        .stat_wr       (stat_wr),
        .stat_wdata    (stat_wdata),
        .err_event     (err_event),
        .bus_busy      (bus_busy),
        .bit_valid     (bit_valid),
        .bit_recessive (bit_recessive),
        .ctrl_rdata    (ctrl_rdata),
        .stat_rdata    (stat_rdata),
        .cfg_wr_en     (cfg_wr_en),
        .tx_en         (tx_en),
        .rx_en         (rx_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [15:0] v);
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr    = 1'b0;
        ctrl_wdata = '0;
    endtask

    task automatic write_stat(input logic [2:0] v, input logic with_event);
        @(negedge clk);
        stat_wr    = 1'b1;
        stat_wdata = v;
        err_event  = with_event;
        @(negedge clk);
        stat_wr    = 1'b0;
        stat_wdata = '0;
        err_event  = 1'b0;
    endtask

    task automatic send_bits(input int n, input logic val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid     = 1'b1;
            bit_recessive = val;
        end
        @(negedge clk);
        bit_valid     = 1'b0;
        bit_recessive = 1'b1;
    endtask

    task automatic t_reset;
        check("R1 status", {29'd0, stat_rdata}, 32'h2);
        check("R1 control", {16'd0, ctrl_rdata}, 32'h0002);
        check("R1 enables", {29'd0, cfg_wr_en, tx_en, rx_en}, 32'h0);
    endtask

    task automatic t_wake;
        write_ctrl(16'h0000);
        send_bits(10, 1'b1);
        check("R4 sleep held after 10 bits", {29'd0, stat_rdata}, 32'h2);
        send_bits(1, 1'b1);
        check("R4 normal after 11 bits", {29'd0, stat_rdata}, 32'h0);
        check("R8 run enables in normal", {29'd0, cfg_wr_en, tx_en, rx_en}, 32'h3);
    endtask

    task automatic t_init_busy;
        @(negedge clk);
        bus_busy = 1'b1;
        write_ctrl(16'h0001);
        repeat (4) @(negedge clk);
        check("R2 held off while busy", {31'd0, stat_rdata[0]}, 32'h0);
        bus_busy = 1'b0;
        @(negedge clk);
        check("R2 one edge after idle", {31'd0, stat_rdata[0]}, 32'h0);
        @(negedge clk);
        check("R2 init ack", {29'd0, stat_rdata}, 32'h1);
        check("R8 config enable in init", {29'd0, cfg_wr_en, tx_en, rx_en}, 32'h4);
    endtask

    task automatic t_idle_restart;
        write_ctrl(16'h0000);
        send_bits(6, 1'b1);
        send_bits(1, 1'b0);
        send_bits(10, 1'b1);
        check("R4 dominant restarts count", {29'd0, stat_rdata}, 32'h1);
        send_bits(1, 1'b1);
        check("R4 normal after restart", {29'd0, stat_rdata}, 32'h0);
        check("R8 config closed in normal", {31'd0, cfg_wr_en}, 32'h0);
    endtask

    task automatic t_sleep;
        write_ctrl(16'h0002);
        check("R3 sleep ack not yet", {29'd0, stat_rdata}, 32'h0);
        @(negedge clk);
        check("R3 sleep ack one edge", {29'd0, stat_rdata}, 32'h0);
        @(negedge clk);
        check("R3 sleep ack", {29'd0, stat_rdata}, 32'h2);
        check("R8 run enables off in sleep", {29'd0, cfg_wr_en, tx_en, rx_en}, 32'h0);
    endtask

    task automatic t_priority;
        write_ctrl(16'h0003);
        repeat (2) @(negedge clk);
        check("R5 init wins", {29'd0, stat_rdata}, 32'h1);
        repeat (5) @(negedge clk);
        check("R5 init held", {29'd0, stat_rdata}, 32'h1);
        write_ctrl(16'h0002);
        @(negedge clk);
        check("R3 init to sleep one edge", {29'd0, stat_rdata}, 32'h1);
        @(negedge clk);
        check("R3 init to sleep", {29'd0, stat_rdata}, 32'h2);
        write_ctrl(16'h0000);
        send_bits(11, 1'b1);
        check("R4 back to normal", {29'd0, stat_rdata}, 32'h0);
    endtask

    task automatic t_err;
        @(negedge clk);
        err_event = 1'b1;
        @(negedge clk);
        err_event = 1'b0;
        check("R7 flag set", {31'd0, stat_rdata[2]}, 32'h1);
        write_stat(3'b011, 1'b0);
        check("R7 zero write keeps flag", {31'd0, stat_rdata[2]}, 32'h1);
        write_stat(3'b100, 1'b0);
        check("R7 one write clears", {31'd0, stat_rdata[2]}, 32'h0);
        write_stat(3'b100, 1'b1);
        check("R7 set beats clear", {31'd0, stat_rdata[2]}, 32'h1);
    endtask

    task automatic t_srst;
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = 16'h8001;
        @(negedge clk);
        ctrl_wr    = 1'b0;
        ctrl_wdata = '0;
        check("R6 status after soft reset", {29'd0, stat_rdata}, 32'h2);
        check("R6 control after soft reset", {16'd0, ctrl_rdata}, 32'h0002);
        check("R6 enables after soft reset", {29'd0, cfg_wr_en, tx_en, rx_en}, 32'h0);
        repeat (4) @(negedge clk);
        check("R6 stays asleep", {29'd0, stat_rdata}, 32'h2);
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst           = 1'b1;
        ctrl_wr       = 1'b0;
        ctrl_wdata    = '0;
        stat_wr       = 1'b0;
        stat_wdata    = '0;
        err_event     = 1'b0;
        bus_busy      = 1'b0;
        bit_valid     = 1'b0;
        bit_recessive = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wake();
        t_init_busy();
        t_idle_restart();
        t_sleep();
        t_priority();
        t_err();
        t_srst();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule